// File: doc/BRIEF.md
# Edge and Band Classification Statistics Collector

This block gathers the per-classification statistics that an offset estimator needs for one coding tree block. Each accepted cycle carries one 4x4 block of reconstructed samples, given as a 6x6 window that includes a one-sample border around the block, and the matching 4x4 block of original samples.

All 16 samples are classified in the same cycle. Sixteen edge classifications are formed: four directions, each with four shape categories. Thirty-two band classifications are formed from the sample value. Each classification gets a 16-bit membership bitmap. From each bitmap the block derives a count, which is the number of member samples. It also derives a signed sum, which is the total of the clipped original-minus-reconstructed differences of the member samples.

The 48 count/sum pairs are accumulated across the blocks of one tree block. The first block of a tree block restarts the accumulation. A one-cycle done pulse marks that the totals are final. Samples whose edge neighbours would fall across a tree-block border are kept out of the edge statistics. The caller signals those borders with a four-bit flag per block.

Top module: `sao_stat_collector`

## Requirements
- R1: The band index of a sample is its value shifted right by SAMPLE_W-5 bits, which gives 32 equal bands. For 8-bit samples 0x96 is band 18. Band b is reported at classification index 16+b.
- R2: For a sample s with direction neighbours a and b, the shape category is decided as follows. Category 1 when s<a and s<b. Category 2 when s is below one neighbour and equal to the other. Category 3 when s is above one neighbour and equal to the other. Category 4 when s>a and s>b. Otherwise no edge classification is set for that direction. Edge classification index = 4*direction + (category-1).
- R3: Direction 0 uses the left and right neighbours. Direction 1 uses the up and down neighbours. Direction 2 uses up-left and down-right. Direction 3 uses up-right and down-left. Block sample (i,j) sits at window row i+1, column j+1; window element (r,c) is at bits (r*6+c)*SAMPLE_W, and original sample (i,j) is at bits (i*4+j)*SAMPLE_W.
- R4: Bits 0 to 3 of the border flag mark the left, right, top and bottom borders of the tree block. A sample is kept out of a direction's edge statistics when either of its two neighbours in that direction lies across a flagged border. Band statistics are never masked.
- R5: The count of a classification grows by the number of member samples in each accepted block.
- R6: The sum of a classification grows by the member samples' original-minus-reconstructed differences, each clipped to the range [-CLIP_LIM, CLIP_LIM].
- R7: A block accepted with the first flag set replaces every total with that block's contribution. A later accepted block adds to the totals. A cycle with in_valid low changes nothing, whatever the other inputs hold.
- R8: When a block is accepted at clock edge k with the last flag set, done is high for exactly the one cycle after edge k+1. In that cycle the outputs hold the final totals, and they stay unchanged until the next block is accepted.
- R9: After reset every count and sum reads zero and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A block is presented this cycle |
| in_first | input | 1 | Block is the first of a tree block |
| in_last | input | 1 | Block is the last of a tree block |
| in_edge | input | 4 | Tree-block border flags: left, right, top, bottom |
| rec_win | input | 36*SAMPLE_W | 6x6 reconstructed window, row-major |
| org_blk | input | 16*SAMPLE_W | 4x4 original samples, row-major |
| done | output | 1 | One-cycle pulse: totals are final |
| cnt_out | output | 48*CNT_W | Per-classification counts, index k at k*CNT_W |
| sum_out | output | 48*SUM_W | Per-classification signed sums, index k at k*SUM_W |

## Verification
A wrong neighbour offset or comparison shows up at done as count and sum mismatches, spread over the edge classifications of one direction. A missing border mask inflates counts only in tree blocks whose flags are set. A stale or uncleared accumulator appears in the second tree block onward, as totals that exceed the model by the previous tree block's values. A misplaced done or an extra pipeline stage is seen at the exact cycle checked after the last block, so every such fault becomes visible no more than two cycles after the final block of the tree block in which it occurs.

// File: rtl/sao_stat_pkg.sv
package sao_stat_pkg;
  localparam int NPIX = 16;            // samples per block
  localparam int NDIR = 4;             // edge directions
  localparam int NCAT = 4;             // shape categories per direction
  localparam int N_EO = NDIR * NCAT;   // edge classifications
  localparam int N_BO = 32;            // bands
  localparam int NCLS = N_EO + N_BO;   // all classifications
  localparam int WIN  = 6;             // window side

  // border flag positions
  localparam int EDGE_L = 0;
  localparam int EDGE_R = 1;
  localparam int EDGE_T = 2;
  localparam int EDGE_B = 3;

  // neighbour offsets for direction d, first (n=0) or second (n=1)
  function automatic int nb_dr(input int d, input int n);
    if (d == 0) return 0;
    return (n == 0) ? -1 : 1;
  endfunction

  function automatic int nb_dc(input int d, input int n);
    case (d)
      0: return (n == 0) ? -1 : 1;
      1: return 0;
      2: return (n == 0) ? -1 : 1;
      default: return (n == 0) ? 1 : -1;
    endcase
  endfunction
endpackage

// File: rtl/sao_eo_classify.sv
module sao_eo_classify
  import sao_stat_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                         rst,
  input  logic [WIN*WIN*SAMPLE_W-1:0]  rec_win,
  input  logic [3:0]                   edge_flag,
  output logic [N_EO*NPIX-1:0]         eo_map
);
  for (genvar i = 0; i < 4; i++) begin : g_row
    for (genvar j = 0; j < 4; j++) begin : g_col
      localparam int P = i * 4 + j;
      localparam int SR = i + 1;
      localparam int SC = j + 1;
      logic [SAMPLE_W-1:0] s;
      logic hmask, vmask;
      assign s = rec_win[(SR*WIN+SC)*SAMPLE_W +: SAMPLE_W];
      assign hmask = ((j == 0) && edge_flag[EDGE_L]) || ((j == 3) && edge_flag[EDGE_R]);
      assign vmask = ((i == 0) && edge_flag[EDGE_T]) || ((i == 3) && edge_flag[EDGE_B]);

      for (genvar d = 0; d < NDIR; d++) begin : g_dir
        localparam int AR = SR + nb_dr(d, 0);
        localparam int AC = SC + nb_dc(d, 0);
        localparam int BR = SR + nb_dr(d, 1);
        localparam int BC = SC + nb_dc(d, 1);
        logic [SAMPLE_W-1:0] na, nb;
        logic lt_a, lt_b, eq_a, eq_b, gt_a, gt_b, masked;
        logic [3:0] cat;
        assign na = rec_win[(AR*WIN+AC)*SAMPLE_W +: SAMPLE_W];
        assign nb = rec_win[(BR*WIN+BC)*SAMPLE_W +: SAMPLE_W];
        assign lt_a = s < na;
        assign lt_b = s < nb;
        assign eq_a = s == na;
        assign eq_b = s == nb;
        assign gt_a = s > na;
        assign gt_b = s > nb;
        assign masked = (d == 0) ? hmask : (d == 1) ? vmask : (hmask | vmask);
        always_comb begin
          cat[0] = lt_a & lt_b;
          cat[1] = (lt_a & eq_b) | (eq_a & lt_b);
          cat[2] = (gt_a & eq_b) | (eq_a & gt_b);
          cat[3] = gt_a & gt_b;
          if (masked) cat = 4'b0000;
          // R2: a sample lands in at most one category per direction
          if (!rst) p_cat_onehot_r2: assert ($onehot0(cat));
        end
        for (genvar c = 0; c < NCAT; c++) begin : g_cat
          assign eo_map[(d*NCAT+c)*NPIX + P] = cat[c];
        end
      end
    end
  end
endmodule

// File: rtl/sao_bo_classify.sv
module sao_bo_classify
  import sao_stat_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                         rst,
  input  logic [WIN*WIN*SAMPLE_W-1:0]  rec_win,
  output logic [N_BO*NPIX-1:0]         bo_map
);
  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    localparam int R = p / 4 + 1;
    localparam int C = p % 4 + 1;
    logic [4:0] band;
    logic [N_BO-1:0] col;
    assign band = rec_win[(R*WIN+C)*SAMPLE_W + SAMPLE_W - 5 +: 5];
    for (genvar b = 0; b < N_BO; b++) begin : g_band
      assign col[b] = (band == 5'(b));
      assign bo_map[b*NPIX + p] = col[b];
    end
    always_comb begin
      // R1: every sample falls in exactly one band
      if (!rst) p_band_onehot_r1: assert ($countones(col) == 1);
    end
  end
endmodule

// File: rtl/sao_cls_reduce.sv
module sao_cls_reduce
  import sao_stat_pkg::*;
#(
  parameter int DW  = 6,
  parameter int BSW = 10
) (
  input  logic [NPIX-1:0]    map,
  input  logic [NPIX*DW-1:0] diffs,
  output logic [4:0]         cnt,
  output logic signed [BSW-1:0] sum
);
  always_comb begin
    cnt = '0;
    sum = '0;
    for (int p = 0; p < NPIX; p++) begin
      logic signed [DW-1:0] d;
      d = diffs[p*DW +: DW];
      if (map[p]) begin
        cnt = cnt + 5'd1;
        sum = sum + BSW'(d);
      end
    end
  end
endmodule

// File: rtl/sao_stat_collector.sv
module sao_stat_collector
  import sao_stat_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int CLIP_LIM    = 31,
  parameter int MAX_SAMPLES = 4096,
  parameter int CNT_W       = $clog2(MAX_SAMPLES + 1),
  parameter int SUM_W       = $clog2(MAX_SAMPLES * CLIP_LIM + 1) + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic                        in_first,
  input  logic                        in_last,
  input  logic [3:0]                  in_edge,
  input  logic [36*SAMPLE_W-1:0]      rec_win,
  input  logic [16*SAMPLE_W-1:0]      org_blk,
  output logic                        done,
  output logic [48*CNT_W-1:0]         cnt_out,
  output logic [48*SUM_W-1:0]         sum_out
);
  localparam int DW  = $clog2(CLIP_LIM + 1) + 1;
  localparam int BSW = $clog2(NPIX * CLIP_LIM + 1) + 1;

  // ---------------- stage 0: classify and difference ----------------
  logic [N_EO*NPIX-1:0] eo_map;
  logic [N_BO*NPIX-1:0] bo_map;
  logic [NPIX*DW-1:0]   diff_c;

  sao_eo_classify #(.SAMPLE_W(SAMPLE_W)) u_eo (
    .rst(rst), .rec_win(rec_win), .edge_flag(in_edge), .eo_map(eo_map));
  sao_bo_classify #(.SAMPLE_W(SAMPLE_W)) u_bo (
    .rst(rst), .rec_win(rec_win), .bo_map(bo_map));

  for (genvar p = 0; p < NPIX; p++) begin : g_diff
    localparam int R = p / 4 + 1;
    localparam int C = p % 4 + 1;
    logic signed [SAMPLE_W:0] raw, lim, clp;
    assign lim = (SAMPLE_W+1)'(CLIP_LIM);
    assign raw = $signed({1'b0, org_blk[p*SAMPLE_W +: SAMPLE_W]})
               - $signed({1'b0, rec_win[(R*WIN+C)*SAMPLE_W +: SAMPLE_W]});
    always_comb begin
      if (raw > lim)       clp = lim;
      else if (raw < -lim) clp = -lim;
      else                 clp = raw;
    end
    assign diff_c[p*DW +: DW] = DW'(clp);
  end

  // ---------------- stage 1: registered bitmaps ----------------
  logic [NCLS*NPIX-1:0] s1_map;
  logic [NPIX*DW-1:0]   s1_diff;
  logic                 s1_vld, s1_first, s1_last;
  logic [3:0]           s1_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_edge  <= '0;
      s1_map   <= '0;
      s1_diff  <= '0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_first <= in_first;
        s1_last  <= in_last;
        s1_edge  <= in_edge;
        s1_map   <= {bo_map, eo_map};
        s1_diff  <= diff_c;
      end
    end
  end

  // ---------------- stage 2: reduce and accumulate ----------------
  logic [4:0]               bcnt    [NCLS];
  logic signed [BSW-1:0]    bsum    [NCLS];
  logic [CNT_W-1:0]         cnt_acc [NCLS];
  logic signed [SUM_W-1:0]  sum_acc [NCLS];

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    sao_cls_reduce #(.DW(DW), .BSW(BSW)) u_red (
      .map(s1_map[k*NPIX +: NPIX]), .diffs(s1_diff),
      .cnt(bcnt[k]), .sum(bsum[k]));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_acc[k] <= '0;
        sum_acc[k] <= '0;
      end else if (s1_vld) begin
        if (s1_first) begin
          cnt_acc[k] <= CNT_W'(bcnt[k]);
          sum_acc[k] <= SUM_W'(bsum[k]);
        end else begin
          cnt_acc[k] <= cnt_acc[k] + CNT_W'(bcnt[k]);
          sum_acc[k] <= sum_acc[k] + SUM_W'(bsum[k]);
        end
      end
    end
    assign cnt_out[k*CNT_W +: CNT_W] = cnt_acc[k];
    assign sum_out[k*SUM_W +: SUM_W] = sum_acc[k];
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= s1_vld & s1_last;
  end

  // ---------------- checks ----------------
  int  bo_total;
  logic h_left_col, v_top_row;
  always_comb begin
    bo_total = 0;
    for (int k = N_EO; k < NCLS; k++) bo_total = bo_total + int'(cnt_acc[k]);
    h_left_col = 1'b0;
    v_top_row  = 1'b0;
    for (int c = 0; c < NCAT; c++) begin
      for (int i = 0; i < 4; i++) h_left_col = h_left_col | s1_map[c*NPIX + i*4];
      for (int j = 0; j < 4; j++) v_top_row  = v_top_row  | s1_map[(NCAT+c)*NPIX + j];
    end
  end

  // R4: a flagged left border leaves column 0 out of horizontal edge maps
  p_mask_left_r4: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_edge[EDGE_L]) |-> !h_left_col);
  // R4: a flagged top border leaves row 0 out of vertical edge maps
  p_mask_top_r4: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_edge[EDGE_T]) |-> !v_top_row);
  // R5: each accumulated block adds exactly 16 band memberships
  p_bo_total_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !s1_first) |=> (bo_total == $past(bo_total) + NPIX));
  // R7: no accepted block, no change
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |=> $stable(bo_total));
  // R8: done is a single-cycle pulse when tree blocks are longer than one block
  p_done_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !(s1_vld && s1_last)) |=> !done);
endmodule

// File: tb/tb_sao_stat_collector.sv
module tb_sao_stat_collector;
  localparam int SW = 8;
  localparam int CLIP = 31;
  localparam int CW = 13;
  localparam int SUMW = 18;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_first, in_last;
  logic [3:0] in_edge;
  logic [36*SW-1:0] rec_win;
  logic [16*SW-1:0] org_blk;
  logic done;
  logic [48*CW-1:0] cnt_out;
  logic [48*SUMW-1:0] sum_out;

  always #4 clk = ~clk;   // 125 MHz

  sao_stat_collector #(.SAMPLE_W(SW), .CLIP_LIM(CLIP)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_edge(in_edge), .rec_win(rec_win), .org_blk(org_blk),
    .done(done), .cnt_out(cnt_out), .sum_out(sum_out));

  int nchk = 0, nfail = 0;
  int rw[6][6];
  int og[4][4];
  int m_cnt[48];
  int m_sum[48];

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v > 0) ? 1 : (v < 0) ? -1 : 0;
  endfunction

  // model of one block's contribution
  task automatic model_add(input bit first, input logic [3:0] e);
    int dr[4][2] = '{'{0,0}, '{-1,1}, '{-1,1}, '{-1,1}};
    int dc[4][2] = '{'{-1,1}, '{0,0}, '{-1,1}, '{1,-1}};
    if (first) for (int k = 0; k < 48; k++) begin m_cnt[k] = 0; m_sum[k] = 0; end
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        int s, d, band;
        bit hm, vm;
        s = rw[i+1][j+1];
        d = og[i][j] - s;
        if (d > CLIP) d = CLIP;
        if (d < -CLIP) d = -CLIP;
        band = s / 8;
        m_cnt[16+band]++;
        m_sum[16+band] += d;
        hm = (j == 0 && e[0]) || (j == 3 && e[1]);
        vm = (i == 0 && e[2]) || (i == 3 && e[3]);
        for (int dir = 0; dir < 4; dir++) begin
          int a, b, t, cat;
          bit m;
          m = (dir == 0) ? hm : (dir == 1) ? vm : (hm || vm);
          a = rw[i+1+dr[dir][0]][j+1+dc[dir][0]];
          b = rw[i+1+dr[dir][1]][j+1+dc[dir][1]];
          t = sgn(s - a) + sgn(s - b);
          cat = (t == -2) ? 0 : (t == -1) ? 1 : (t == 1) ? 2 : (t == 2) ? 3 : -1;
          if (!m && cat >= 0) begin
            m_cnt[dir*4+cat]++;
            m_sum[dir*4+cat] += d;
          end
        end
      end
    end
  endtask

  task automatic pack();
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 6; c++) rec_win[(r*6+c)*SW +: SW] = SW'(rw[r][c]);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) org_blk[(i*4+j)*SW +: SW] = SW'(og[i][j]);
  endtask

  task automatic compare(input string tag);
    for (int k = 0; k < 48; k++) begin
      int ac, as;
      ac = int'(cnt_out[k*CW +: CW]);
      as = int'($signed(sum_out[k*SUMW +: SUMW]));
      check($sformatf("%s R5 cnt[%0d]", tag, k), ac, m_cnt[k]);
      check($sformatf("%s R6 sum[%0d]", tag, k), as, m_sum[k]);
    end
  endtask

  // one cycle of input; valid blocks update the model
  task automatic drive(input bit v, input bit f, input bit l, input logic [3:0] e);
    @(negedge clk);
    pack();
    in_valid = v; in_first = f; in_last = l; in_edge = e;
    @(posedge clk);
    if (v) model_add(f, e);
    if (v && l) begin
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #1;
      check("R8 done after last", int'(done), 1);
      compare("R7/R8 final totals");
      @(posedge clk); #1;
      check("R8 done single cycle", int'(done), 0);
      compare("R8 totals held");
    end
  endtask

  task automatic rand_block(input int mode);
    int base;
    base = int'($urandom_range(200, 20));
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 6; c++)
        rw[r][c] = (mode == 0) ? int'($urandom_range(255, 0)) : base + int'($urandom_range(2, 0));
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        int o;
        o = rw[i+1][j+1] + int'($urandom_range(90, 0)) - 45;
        og[i][j] = (o < 0) ? 0 : (o > 255) ? 255 : o;
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired R8 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 0; in_first = 0; in_last = 0; in_edge = 0;
    rec_win = '0; org_blk = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    // R9: reset state
    check("R9 done low", int'(done), 0);
    check("R9 counts zero", int'(cnt_out != '0), 0);
    check("R9 sums zero", int'(sum_out != '0), 0);

    // R1: flat block at 0x96, diff +5: band 18 only, no edge shape
    for (int r = 0; r < 6; r++) for (int c = 0; c < 6; c++) rw[r][c] = 'h96;
    for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) og[i][j] = 'h96 + 5;
    drive(1, 1, 1, 4'b0000);
    check("R1 band 18 count", int'(cnt_out[34*CW +: CW]), 16);
    check("R6 band 18 sum", int'($signed(sum_out[34*SUMW +: SUMW])), 80);
    check("R2 flat no edge", int'(cnt_out[15*CW +: CW]), 0);

    // R2/R3/R4: checkerboard with all borders flagged; large diffs hit clip
    for (int r = 0; r < 6; r++) for (int c = 0; c < 6; c++) rw[r][c] = ((r + c) % 2) ? 200 : 10;
    for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) og[i][j] = ((i + j) % 2) ? 0 : 255;
    drive(1, 1, 1, 4'b1111);
    check("R4 horiz peaks masked to inner cols", int'(cnt_out[3*CW +: CW]), 4);
    check("R3 vert valleys", int'(cnt_out[4*CW +: CW]), 4);
    check("R6 clipped valley sum", int'($signed(sum_out[0*SUMW +: SUMW])), 4 * CLIP);

    // R7/R4: luma-sized tree block, random data, idle gaps with junk
    for (int b = 0; b < 256; b++) begin
      logic [3:0] e;
      int bx, by;
      bx = b % 16; by = b / 16;
      e = {by == 15, by == 0, bx == 15, bx == 0};
      if ($urandom_range(7, 0) == 0) begin
        rand_block(0);
        drive(0, 1, 1, 4'b0000);   // R7: ignored cycle
      end
      rand_block(b % 2);
      drive(1, b == 0, b == 255, e);
    end

    // R7: chroma-sized tree block restarts totals; narrow values
    for (int b = 0; b < 64; b++) begin
      logic [3:0] e;
      int bx, by;
      bx = b % 8; by = b / 8;
      e = {by == 7, by == 0, bx == 7, bx == 0};
      rand_block(1);
      drive(1, b == 0, b == 63, e);
    end

    // R4: random tree blocks with random border flags
    for (int t = 0; t < 4; t++) begin
      for (int b = 0; b < 8; b++) begin
        rand_block(t % 2);
        drive(1, b == 0, b == 7, 4'($urandom_range(15, 0)));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule